// File: doc/BRIEF.md
# Paged Serial EEPROM Write Sequencer

This block is an SPI host that programs a serial EEPROM from a byte stream. It is given a start offset, a byte count, the device size, the page size (as a power of two) and an address mode. It then breaks the transfer into page-bounded segments. For each segment it latches the device's write enable in its own transaction. It then sends the write command, the address bytes and the segment data, and polls the device status until the busy bit drops.

The bytes are pulled from the source one at a time. The block pulses `wr_take` each time it consumes `wr_data`, and the source then presents the next byte. Polling runs on a millisecond interval that is derived from the clock frequency. A device that stays busy past the timeout window ends the transfer with an error. A request that starts outside the device is refused before any SPI activity takes place.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, and `done`, `busy`, `err_range` and `err_timeout` are all low.
- R2: A start offset equal to or above `mem_bytes` ends the request with `done` and `err_range` set, and chip select never goes low.
- R3: When offset plus count exceeds `mem_bytes`, the count is cut so the transfer stops at the last byte. A count that is zero ends with `done` and `err_range`.
- R4: Every segment has length min(page − (offset mod page), bytes left), where page = 2^`page_log2`. No segment is empty, and no segment crosses a page boundary.
- R5: Each segment starts with a one-byte transaction carrying 0x06. A separate transaction follows that carries the write opcode 0x02, then the address, then the segment data. Chip select returns high between transactions.
- R6: After each write, the block repeats a two-byte transaction (0x05, then one byte read back) while bit 0 of the byte read back is 1. It moves on only after reading a 0 in bit 0.
- R7: If bit 0 is still 1 once TIMEOUT_MS milliseconds of polling have elapsed, the block stops with `done` and `err_timeout` set, and it issues no further writes.
- R8: In address mode 1 (9-bit), the write opcode becomes 0x0A when the segment offset is 256 or more. In that mode a single address byte carries offset bits 7:0.
- R9: `addr_mode` 0 sends one address byte, 2 sends two and 3 sends three. The address is sent most significant byte first.
- R10: SPI runs in mode 0. `spi_sclk` is low while `spi_cs_n` is high, `spi_mosi` is stable while `spi_sclk` is high, and bits go out MSB first.
- R11: `wr_take` pulses once for each data byte sent, and the bytes are sent in stream order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (accepted when not busy) |
| start_off | input | ADDR_W | First byte offset |
| byte_cnt | input | CNT_W | Number of bytes requested |
| page_log2 | input | PLOG_W | log2 of the page size |
| mem_bytes | input | ADDR_W+1 | Device size in bytes |
| addr_mode | input | 2 | 0: 8-bit, 1: 9-bit, 2: 16-bit, 3: 24-bit address |
| wr_data | input | 8 | Current byte of the stream |
| wr_take | output | 1 | Pulse: `wr_data` consumed |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Host data out |
| spi_miso | input | 1 | Device data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| err_range | output | 1 | Request refused (offset or count), held until next start |
| err_timeout | output | 1 | Device stayed busy too long, held until next start |

## Verification
The hardest condition to reach from the ports is a device that stays busy until the timeout expires. Reaching it requires a device model that keeps answering busy, across several polls spaced a millisecond apart. The bench's device model counts status reads and can be told to report busy for any number of them after each write. Setting that number far past the window forces the timeout. Setting it to one or two checks that the block polls again and then resumes mid-transfer. A second corner is a segment that crosses the 256-byte line in 9-bit mode. It is reached by starting a few bytes below 256 with a 16-byte page, so that the second segment lands on offset 256 exactly.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEG, ST_WREN, ST_GAP_A, ST_WRITE, ST_GAP_B, ST_POLL, ST_WAIT
  } wstate_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_HIBIT = 8'h08;

  localparam logic [1:0] AM_8  = 2'd0;
  localparam logic [1:0] AM_9  = 2'd1;
  localparam logic [1:0] AM_16 = 2'd2;
  localparam logic [1:0] AM_24 = 2'd3;

  function automatic logic [1:0] addr_bytes(input logic [1:0] mode);
    case (mode)
      AM_16:   return 2'd2;
      AM_24:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/eepw_spi_shift.sv
module eepw_spi_shift #(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] cnt;
  logic [2:0]    bits;
  logic [7:0]    sh;
  logic          active;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; bits <= '0; sh <= '0; active <= 1'b0;
      sclk <= 1'b0; done <= 1'b0; rx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh <= tx; active <= 1'b1; cnt <= '0; bits <= '0;
      end else if (active) begin
        if (cnt == HW'(HALF - 1)) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bits == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bits <= bits + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + HW'(1);
        end
      end
    end
  end

  // R10: data may only change while the clock is low
  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
endmodule

// File: rtl/eepw_seg_calc.sv
module eepw_seg_calc #(
  parameter int AW     = 25,
  parameter int CNT_W  = 16,
  parameter int PLOG_W = 5
) (
  input  logic [AW-1:0]     off,
  input  logic [PLOG_W-1:0] plog,
  input  logic [CNT_W-1:0]  remain,
  output logic [CNT_W-1:0]  seg
);
  logic [AW-1:0] page, room;

  always_comb begin
    page = AW'(1) << plog;
    room = page - (off & (page - AW'(1)));
    seg  = (room < AW'(remain)) ? room[CNT_W-1:0] : remain;
  end
endmodule

// File: rtl/eepw_poll_timer.sv
module eepw_poll_timer #(
  parameter int MS_CYC  = 50000,
  parameter int TMO_CYC = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic waiting,
  output logic gap_up,
  output logic expired
);
  localparam int EW = $clog2(TMO_CYC + 1);
  localparam int IW = $clog2(MS_CYC + 1);

  logic [EW-1:0] elapsed;
  logic [IW-1:0] ivl;

  assign expired = (elapsed >= EW'(TMO_CYC));
  assign gap_up  = waiting && (ivl == IW'(MS_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clr)     elapsed <= '0;
    else if (!expired)  elapsed <= elapsed + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !waiting) ivl <= '0;
    else                 ivl <= ivl + IW'(1);
  end

  // R7: the window counter never moves past its limit
  p_elapsed_sat_r7: assert property (@(posedge clk) disable iff (rst)
    $past(expired) && !$past(clr) |-> $stable(elapsed));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PLOG_W     = 5,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 25,
  parameter int SCK_HALF   = 4,
  parameter int CS_GAP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_off,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [PLOG_W-1:0] page_log2,
  input  logic [ADDR_W:0]   mem_bytes,
  input  logic [1:0]        addr_mode,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              done,
  output logic              err_range,
  output logic              err_timeout
);
  localparam int W       = ADDR_W + 1;
  localparam int IDX_W   = CNT_W + 2;
  localparam int MS_CYC  = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int TMO_CYC = MS_CYC * TIMEOUT_MS;
  localparam int GW      = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  wstate_t           state;
  logic [W-1:0]      cur_off;
  logic [CNT_W-1:0]  remain, seg_len, seg_nxt;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [GW-1:0]     gap_cnt;
  logic [1:0]        mode_r;
  logic [PLOG_W-1:0] plog_r;
  logic              launch;

  // request check and clipping
  logic [W-1:0] off_ext, avail, eff;
  logic         out_rng;
  always_comb begin
    off_ext = W'(start_off);
    avail   = mem_bytes - off_ext;
    eff     = (W'(byte_cnt) > avail) ? avail : W'(byte_cnt);
    out_rng = (off_ext >= mem_bytes);
  end

  eepw_seg_calc #(.AW(W), .CNT_W(CNT_W), .PLOG_W(PLOG_W)) u_seg (
    .off(cur_off), .plog(plog_r), .remain(remain), .seg(seg_nxt));

  // byte chooser
  logic [1:0]  alen, asel;
  logic [7:0]  opcode, abyte, tx_byte;
  logic [31:0] off32;
  always_comb begin
    alen   = addr_bytes(mode_r);
    off32  = 32'(cur_off);
    asel   = alen - idx[1:0];
    abyte  = 8'(off32 >> {asel, 3'b000});
    opcode = OP_WRITE | (((mode_r == AM_9) && (cur_off[W-1:8] != '0)) ? OP_HIBIT : 8'h00);
    case (state)
      ST_WREN:  tx_byte = OP_WREN;
      ST_POLL:  tx_byte = (idx == '0) ? OP_RDSR : 8'h00;
      ST_WRITE: tx_byte = (idx == '0) ? opcode :
                          (idx <= IDX_W'(alen)) ? abyte : wr_data;
      default:  tx_byte = 8'h00;
    endcase
  end

  logic       sh_done;
  logic [7:0] sh_rx;
  eepw_spi_shift #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(launch), .tx(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx));

  logic gap_up, expired;
  eepw_poll_timer #(.MS_CYC(MS_CYC), .TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .clr(state == ST_GAP_B), .waiting(state == ST_WAIT),
    .gap_up(gap_up), .expired(expired));

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cur_off <= '0; remain <= '0; seg_len <= '0;
      idx <= '0; last_idx <= '0; gap_cnt <= '0; mode_r <= '0; plog_r <= '0;
      launch <= 1'b0; spi_cs_n <= 1'b1; wr_take <= 1'b0; done <= 1'b0;
      err_range <= 1'b0; err_timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      launch  <= 1'b0;
      wr_take <= launch && (state == ST_WRITE) && (idx > IDX_W'(alen));
      if (launch) idx <= idx;
      case (state)
        ST_IDLE: if (start) begin
          err_range <= 1'b0; err_timeout <= 1'b0;
          mode_r <= addr_mode; plog_r <= page_log2;
          cur_off <= off_ext; remain <= eff[CNT_W-1:0];
          if (out_rng || eff == '0) begin
            err_range <= 1'b1; done <= 1'b1;
          end else begin
            state <= ST_SEG;
          end
        end
        ST_SEG: begin
          seg_len <= seg_nxt; idx <= '0; last_idx <= '0;
          spi_cs_n <= 1'b0; launch <= 1'b1; state <= ST_WREN;
        end
        ST_GAP_A, ST_GAP_B: begin
          gap_cnt <= gap_cnt + GW'(1);
          if (gap_cnt == GW'(CS_GAP - 1)) begin
            gap_cnt <= '0; idx <= '0; spi_cs_n <= 1'b0; launch <= 1'b1;
            if (state == ST_GAP_A) begin
              last_idx <= IDX_W'(alen) + IDX_W'(seg_len);
              state    <= ST_WRITE;
            end else begin
              last_idx <= IDX_W'(1);
              state    <= ST_POLL;
            end
          end
        end
        ST_WAIT: if (gap_up) begin
          idx <= '0; spi_cs_n <= 1'b0; launch <= 1'b1; state <= ST_POLL;
        end
        default: if (sh_done) begin   // ST_WREN, ST_WRITE, ST_POLL
          if (idx != last_idx) begin
            idx <= idx + IDX_W'(1); launch <= 1'b1;
          end else begin
            spi_cs_n <= 1'b1;
            if (state == ST_WREN)       state <= ST_GAP_A;
            else if (state == ST_WRITE) state <= ST_GAP_B;
            else if (!sh_rx[0]) begin
              cur_off <= cur_off + W'(seg_len);
              remain  <= remain - seg_len;
              if (remain == seg_len) begin
                done <= 1'b1; state <= ST_IDLE;
              end else begin
                state <= ST_SEG;
              end
            end else if (expired) begin
              err_timeout <= 1'b1; done <= 1'b1; state <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
      endcase
    end
  end

  // assertions
  logic [W-1:0] page_w;
  assign page_w = W'(1) << plog_r;

  p_seg_fits_r4: assert property (@(posedge clk) disable iff (rst)
    state == ST_WRITE |-> (seg_len != '0) &&
      ((cur_off & (page_w - W'(1))) + W'(seg_len) <= page_w));
  p_range_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    err_range |-> spi_cs_n);
  p_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(err_range && err_timeout));
  p_take_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (state == ST_WRITE) && !spi_cs_n);
  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int TMO = 250;   // 10 cycles/ms * 25 ms

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] start_off = '0;
  logic [15:0] byte_cnt = '0;
  logic [4:0]  page_log2 = '0;
  logic [24:0] mem_bytes = '0;
  logic [1:0]  addr_mode = '0;
  logic [7:0]  wr_data;
  logic wr_take, spi_sclk, spi_cs_n, spi_mosi, busy, done, err_range, err_timeout;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  eeprom_page_writer #(.CLK_HZ(10000), .SCK_HALF(2), .CS_GAP(2)) u0 (
    .clk(clk), .rst(rst), .start(start), .start_off(start_off), .byte_cnt(byte_cnt),
    .page_log2(page_log2), .mem_bytes(mem_bytes), .addr_mode(addr_mode),
    .wr_data(wr_data), .wr_take(wr_take), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy), .done(done),
    .err_range(err_range), .err_timeout(err_timeout));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // byte stream source
  int sidx = 0;
  function automatic logic [7:0] src(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction
  assign wr_data = src(sidx);
  always @(negedge clk) if (wr_take) sidx++;

  // device model and transaction log
  logic [7:0] blog [0:1023];
  int tbeg [0:127];
  int tlen [0:127];
  int nb = 0, ntx = 0, bitn = 0, busy_left = 0, busy_cfg = 0;
  bit logging = 0;
  logic [7:0] shin = '0, msh = '0;
  int mode_viol = 0;

  always @(negedge spi_cs_n) if (logging) begin
    bitn = 0; tbeg[ntx] = nb;
  end
  always @(posedge spi_cs_n) if (logging) begin
    tlen[ntx] = nb - tbeg[ntx];
    if (tlen[ntx] > 0 && (blog[tbeg[ntx]] == 8'h02 || blog[tbeg[ntx]] == 8'h0A))
      busy_left = busy_cfg;
    ntx++;
  end
  always @(posedge spi_sclk) if (logging && !spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    bitn++;
    if (bitn % 8 == 0) begin
      blog[nb] = shin; nb++;
      if (bitn == 8 && shin == 8'h05) begin
        msh = (busy_left > 0) ? 8'h01 : 8'h00;
        if (busy_left > 0) busy_left--;
      end
    end
  end
  always @(negedge spi_sclk) begin
    spi_miso <= msh[7];
    msh <= {msh[6:0], 1'b0};
  end
  always @(negedge clk) if (!rst && spi_cs_n && spi_sclk) mode_viol++;

  int run_cyc;
  task automatic run(input int off, input int cnt, input int plog, input int size,
                     input int mode, input int bsy);
    @(negedge clk);
    start_off = 24'(off); byte_cnt = 16'(cnt); page_log2 = 5'(plog);
    mem_bytes = 25'(size); addr_mode = 2'(mode);
    ntx = 0; nb = 0; sidx = 0; busy_cfg = bsy; busy_left = 0; logging = 1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    run_cyc = 0;
    while (!done && run_cyc < 50000) begin @(negedge clk); run_cyc++; end
  endtask

  // expected transaction stream for a successful transfer
  task automatic verify(input int off, input int cnt, input int plog, input int size,
                        input int mode, input int bsy);
    int eff, o, rem, ti, k, page, seg, alen, op;
    eff = (off + cnt > size) ? size - off : cnt;
    chk(done && !err_range && !err_timeout, "R3 clean completion", err_range, 0);
    o = off; rem = eff; ti = 0; k = 0; page = 1 << plog;
    alen = (mode == 3) ? 3 : (mode == 2) ? 2 : 1;
    while (rem > 0) begin
      seg = page - (o % page);
      if (seg > rem) seg = rem;
      chk(tlen[ti] == 1 && blog[tbeg[ti]] == 8'h06, "R5 write-enable txn",
          int'(blog[tbeg[ti]]), 6);
      ti++;
      op = 2 | ((mode == 1 && o >= 256) ? 8 : 0);
      chk(tlen[ti] == 1 + alen + seg, "R4 segment length", tlen[ti], 1 + alen + seg);
      chk(int'(blog[tbeg[ti]]) == op, "R8 write opcode", int'(blog[tbeg[ti]]), op);
      for (int a = 0; a < alen; a++)
        chk(int'(blog[tbeg[ti] + 1 + a]) == ((o >> (8 * (alen - 1 - a))) & 255),
            "R9 address byte", int'(blog[tbeg[ti] + 1 + a]),
            (o >> (8 * (alen - 1 - a))) & 255);
      for (int d = 0; d < seg; d++)
        chk(blog[tbeg[ti] + 1 + alen + d] == src(k + d), "R11 data byte order",
            int'(blog[tbeg[ti] + 1 + alen + d]), int'(src(k + d)));
      ti++;
      for (int p = 0; p <= bsy; p++) begin
        chk(tlen[ti] == 2 && blog[tbeg[ti]] == 8'h05, "R6 status poll",
            int'(blog[tbeg[ti]]), 5);
        ti++;
      end
      o += seg; rem -= seg; k += seg;
    end
    chk(ntx == ti, "R4 transaction count", ntx, ti);
    chk(sidx == eff, "R11 bytes taken", sidx, eff);
  endtask

  task automatic t_reset();
    chk(spi_cs_n && !spi_sclk && !done && !busy && !err_range && !err_timeout,
        "R1 reset state", {spi_cs_n, spi_sclk, done, busy, err_range, err_timeout}, 32);
  endtask
  task automatic t_paged16();   // segments 6,16,16,2
    run(10, 40, 4, 4096, 2, 1); verify(10, 40, 4, 4096, 2, 1);
  endtask
  task automatic t_single8();
    run(3, 5, 3, 256, 0, 0); verify(3, 5, 3, 256, 0, 0);
  endtask
  task automatic t_ninebit();   // crosses offset 256
    run(250, 20, 4, 512, 1, 2); verify(250, 20, 4, 512, 1, 2);
  endtask
  task automatic t_clip24();    // R3 truncated to 8 bytes
    run(32'hFFFF8, 20, 6, 32'h100000, 3, 0); verify(32'hFFFF8, 20, 6, 32'h100000, 3, 0);
    chk(sidx == 8, "R3 clipped count", sidx, 8);
  endtask
  task automatic t_range();
    run(4096, 4, 4, 4096, 2, 0);
    chk(done && err_range && !err_timeout, "R2 offset beyond size", err_range, 1);
    chk(ntx == 0, "R2 no SPI activity", ntx, 0);
  endtask
  task automatic t_zero();
    run(100, 0, 4, 4096, 2, 0);
    chk(done && err_range, "R3 zero count", err_range, 1);
    chk(ntx == 0, "R3 zero count quiet", ntx, 0);
  endtask
  task automatic t_timeout();
    int nwr;
    run(0, 4, 4, 4096, 2, 1000);
    chk(done && err_timeout && !err_range, "R7 timeout flag", err_timeout, 1);
    chk(run_cyc >= TMO, "R7 timeout not early", run_cyc, TMO);
    nwr = 0;
    for (int i = 0; i < ntx; i++) if (blog[tbeg[i]] == 8'h02) nwr++;
    chk(nwr == 1, "R7 no further writes", nwr, 1);
    chk(blog[tbeg[ntx - 1]] == 8'h05, "R7 ended in poll", int'(blog[tbeg[ntx - 1]]), 5);
    repeat (200) @(negedge clk);
    chk(!busy && spi_cs_n, "R7 idle after timeout", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_paged16();
    t_single8();
    t_ninebit();
    t_clip24();
    t_range();
    t_zero();
    t_timeout();
    chk(mode_viol == 0, "R10 clock idle while deselected", mode_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule